// File: doc/BRIEF.md
# FIFO Threshold Request Generator

This block watches the fill state of an eight-entry receive FIFO and an eight-entry transmit FIFO and tells the rest of the system when enough data or space is available to be worth moving. On the receive side it counts filled entries; on the transmit side it counts free slots, taken as the depth minus the transmit occupancy. Each side has a 2-bit code that selects a power-of-two threshold of 1, 2, 4 or 8.

A single mode input picks how the result is delivered. With the mode at 0 the block drives burst-request lines toward a DMA engine: a request is up whenever a full burst of the programmed size can be moved. With the mode at 1 (programmed I/O) it instead keeps sticky event bits. An event is set when the threshold condition becomes true and stays set until software writes 1 to its clear strobe. Two status outputs show the raw threshold condition at all times, whatever the enable, the mode or the events.

Top module: `fifo_thresh_req`

## Requirements
- R1: The receive code maps 0→1, 1→2, 2→4, 3→8 filled entries. `rxLevel` is 1 one clock after `rxCount` is at or above the selected threshold, and 0 one clock after it is below.
- R2: The transmit free-slot count is 8 − `txCount`, or 0 when `txCount` exceeds 8. The transmit code uses the same mapping (0→1, 1→2, 2→4, 3→8 free slots). `txLevel` is 1 one clock after the free-slot count is at or above that threshold.
- R3: `rxLevel` and `txLevel` follow the threshold condition even while `enable` is 0, in either mode, and whatever the state of the events.
- R4: With `enable`=1 and `pioMode`=0, each of `rxDmaReq` and `txDmaReq` equals its side's threshold condition, registered one clock later. It drops one clock after the condition goes away.
- R5: With `enable`=1 and `pioMode`=1, an event bit is set one clock after its side's condition becomes true. Entering PIO operation (enabling, or switching the mode) while the condition already holds counts as it becoming true.
- R6: In PIO operation an event bit stays set, even after the condition goes away, until its clear strobe is 1 for a clock. It reads 0 one clock after that. A clear strobe of 0 has no effect.
- R7: If a new rising condition and a clear strobe fall in the same clock, the event remains set.
- R8: When `enable`=0 or `pioMode`=0, both event bits read 0 one clock later. When `enable`=0 or `pioMode`=1, both DMA requests read 0 one clock later.
- R9: While `rstN` is low, all six outputs are 0.
- R10: An event cleared while its condition is still true is not set again. It sets again only after the condition goes false and then true again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Enables requests and events |
| pioMode | input | 1 | 0 = DMA burst requests, 1 = programmed-I/O events |
| rxThrCode | input | 2 | Receive threshold code (1/2/4/8 filled entries) |
| txThrCode | input | 2 | Transmit threshold code (1/2/4/8 free slots) |
| rxCount | input | 4 | Receive FIFO filled entries |
| txCount | input | 4 | Transmit FIFO occupancy |
| rxEvtClr | input | 1 | Write-1 clear for the receive event |
| txEvtClr | input | 1 | Write-1 clear for the transmit event |
| rxDmaReq | output | 1 | Receive burst request (DMA mode) |
| txDmaReq | output | 1 | Transmit burst request (DMA mode) |
| rxEvent | output | 1 | Sticky receive event (PIO mode) |
| txEvent | output | 1 | Sticky transmit event (PIO mode) |
| rxLevel | output | 1 | Receive threshold condition status |
| txLevel | output | 1 | Transmit threshold condition status |

## Verification
Every output sits one register after the inputs. A change to the counts, codes, mode, enable or clear strobes made in one clock is therefore due on the outputs just after the next rising edge. The driver applies each set of inputs on a falling edge and queues the six output values it predicts from the requirements for the next rising edge. The monitor pops that entry one nanosecond after the rising edge and compares it, so each check lines up with exactly one input cycle.

// File: rtl/fthr_pkg.sv
package fthr_pkg;
  localparam int NCH   = 2;
  localparam int CH_RX = 0;
  localparam int CH_TX = 1;

  // strobes passed from the datapath to the control
  typedef struct packed {
    logic [NCH-1:0] rise;    // armed condition just became true
    logic [NCH-1:0] burst;   // DMA burst available this cycle
    logic           pioLive; // enabled and in programmed-I/O mode
  } thrStrobes_t;
endpackage

// File: rtl/fthr_datapath.sv
module fthr_datapath
  import fthr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CODE_W = 2,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              pioMode,
  input  logic [CODE_W-1:0] rxThrCode,
  input  logic [CODE_W-1:0] txThrCode,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txCount,
  output thrStrobes_t       strb,
  output logic [NCH-1:0]    levelQ
);
  localparam int MAX_SH = (1 << CODE_W) - 1;
  localparam int CMP_W  = (CNT_W > MAX_SH + 1) ? CNT_W : MAX_SH + 1;

  logic [CMP_W-1:0]  avail  [NCH];
  logic [CMP_W-1:0]  thresh [NCH];
  logic [CODE_W-1:0] code   [NCH];
  logic [NCH-1:0]    hit;
  logic [NCH-1:0]    armNow;
  logic [NCH-1:0]    armQ;

  assign code[CH_RX] = rxThrCode;
  assign code[CH_TX] = txThrCode;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_side
    if (ch == CH_RX) begin : g_filled
      assign avail[ch] = CMP_W'(rxCount);
    end else begin : g_free
      assign avail[ch] = (int'(txCount) > DEPTH) ? '0
                       : CMP_W'(DEPTH) - CMP_W'(txCount);
    end
    assign thresh[ch] = CMP_W'(1) << code[ch];
    assign hit[ch]    = avail[ch] >= thresh[ch];
  end

  assign armNow = (enable && pioMode) ? hit : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      armQ   <= '0;
    end else begin
      levelQ <= hit;
      armQ   <= armNow;
    end
  end

  assign strb.rise    = armNow & ~armQ;
  assign strb.burst   = (enable && !pioMode) ? hit : '0;
  assign strb.pioLive = enable && pioMode;
endmodule

// File: rtl/fthr_control.sv
module fthr_control
  import fthr_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  thrStrobes_t    strb,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] evtQ,
  output logic [NCH-1:0] reqQ
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        evtQ[ch] <= 1'b0;
        reqQ[ch] <= 1'b0;
      end else begin
        reqQ[ch] <= strb.burst[ch];
        if (!strb.pioLive)
          evtQ[ch] <= 1'b0;
        else
          evtQ[ch] <= strb.rise[ch] | (evtQ[ch] & ~clr[ch]);
      end
    end
  end
endmodule

// File: rtl/fifo_thresh_req.sv
module fifo_thresh_req
  import fthr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CODE_W = 2,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              pioMode,
  input  logic [CODE_W-1:0] rxThrCode,
  input  logic [CODE_W-1:0] txThrCode,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txCount,
  input  logic              rxEvtClr,
  input  logic              txEvtClr,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              rxEvent,
  output logic              txEvent,
  output logic              rxLevel,
  output logic              txLevel
);
  thrStrobes_t    strb;
  logic [NCH-1:0] levelQ;
  logic [NCH-1:0] evtQ;
  logic [NCH-1:0] reqQ;
  logic [NCH-1:0] clr;

  assign clr[CH_RX] = rxEvtClr;
  assign clr[CH_TX] = txEvtClr;

  fthr_datapath #(.DEPTH(DEPTH), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .pioMode(pioMode),
    .rxThrCode(rxThrCode), .txThrCode(txThrCode),
    .rxCount(rxCount), .txCount(txCount),
    .strb(strb), .levelQ(levelQ)
  );

  fthr_control u_ctl (
    .clk(clk), .rstN(rstN), .strb(strb), .clr(clr),
    .evtQ(evtQ), .reqQ(reqQ)
  );

  assign rxDmaReq = reqQ[CH_RX];
  assign txDmaReq = reqQ[CH_TX];
  assign rxEvent  = evtQ[CH_RX];
  assign txEvent  = evtQ[CH_TX];
  assign rxLevel  = levelQ[CH_RX];
  assign txLevel  = levelQ[CH_TX];
endmodule

// File: rtl/fthr_checker.sv
module fthr_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic pioMode,
  input logic rxEvtClr,
  input logic txEvtClr,
  input logic rxDmaReq,
  input logic txDmaReq,
  input logic rxEvent,
  input logic txEvent,
  input logic rxLevel,
  input logic txLevel
);
  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !rxDmaReq && !txDmaReq && !rxEvent && !txEvent);

  // R8
  dma_mode_no_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pioMode |=> !rxEvent && !txEvent);

  // R8
  pio_mode_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    pioMode |=> !rxDmaReq && !txDmaReq);

  // R4
  rx_req_needs_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq |-> rxLevel);

  // R4
  tx_req_needs_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> txLevel);

  // R5
  rx_event_rise_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEvent) |-> rxLevel);

  // R6
  rx_event_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxEvent && !rxEvtClr && enable && pioMode |=> rxEvent);

  // R6
  tx_event_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEvent && !txEvtClr && enable && pioMode |=> txEvent);

  // R8
  req_event_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDmaReq && rxEvent) && !(txDmaReq && txEvent));
endmodule

bind fifo_thresh_req fthr_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .pioMode(pioMode),
  .rxEvtClr(rxEvtClr), .txEvtClr(txEvtClr),
  .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
  .rxEvent(rxEvent), .txEvent(txEvent),
  .rxLevel(rxLevel), .txLevel(txLevel)
);

// File: tb/fifo_thresh_req_test.sv
module fifo_thresh_req_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, pioMode = 1'b0;
  logic [1:0] rxThrCode = '0, txThrCode = '0;
  logic [3:0] rxCount = '0, txCount = '0;
  logic rxEvtClr = 1'b0, txEvtClr = 1'b0;
  logic rxDmaReq, txDmaReq, rxEvent, txEvent, rxLevel, txLevel;

  always #2 clk = ~clk;

  fifo_thresh_req uut (
    .clk(clk), .rstN(rstN), .enable(enable), .pioMode(pioMode),
    .rxThrCode(rxThrCode), .txThrCode(txThrCode),
    .rxCount(rxCount), .txCount(txCount),
    .rxEvtClr(rxEvtClr), .txEvtClr(txEvtClr),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
    .rxEvent(rxEvent), .txEvent(txEvent),
    .rxLevel(rxLevel), .txLevel(txLevel)
  );

  typedef struct {
    logic [5:0] vals; // {rxDmaReq,txDmaReq,rxEvent,txEvent,rxLevel,txLevel}
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // independent model state
  bit mArm[2];
  bit mEvt[2];

  function automatic bit rxHitOf(int cnt, int code);
    return cnt >= (1 << code);
  endfunction

  function automatic bit txHitOf(int occ, int code);
    int freeSlots;
    freeSlots = (occ > 8) ? 0 : 8 - occ;
    return freeSlots >= (1 << code);
  endfunction

  // driver: apply inputs, predict outputs due after the next rising edge
  task automatic step(input bit en, input bit pio, input int rc, input int tc,
                      input int rcode, input int tcode,
                      input bit rclr, input bit tclr, input string tag);
    bit hit[2], arm[2], clr[2], req[2];
    expItem_t it;
    @(negedge clk);
    enable = en; pioMode = pio;
    rxCount = 4'(rc); txCount = 4'(tc);
    rxThrCode = 2'(rcode); txThrCode = 2'(tcode);
    rxEvtClr = rclr; txEvtClr = tclr;
    hit[0] = rxHitOf(rc, rcode);
    hit[1] = txHitOf(tc, tcode);
    clr[0] = rclr; clr[1] = tclr;
    for (int c = 0; c < 2; c++) begin
      arm[c] = en && pio && hit[c];
      req[c] = en && !pio && hit[c];
      if (en && pio) mEvt[c] = (arm[c] && !mArm[c]) || (mEvt[c] && !clr[c]);
      else           mEvt[c] = 1'b0;
      mArm[c] = arm[c];
    end
    it.vals = {req[0], req[1], mEvt[0], mEvt[1], hit[0], hit[1]};
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare one entry just after each rising edge
  always @(posedge clk) begin
    expItem_t it;
    logic [5:0] act;
    #1;
    if (expQ.size() > 0) begin
      it  = expQ.pop_front();
      act = {rxDmaReq, txDmaReq, rxEvent, txEvent, rxLevel, txLevel};
      checks++;
      if (act !== it.vals) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b", it.tag, act, it.vals);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset state, with inputs that would otherwise raise outputs
    enable = 1'b1; pioMode = 1'b0; rxCount = 4'd8; txCount = 4'd0;
    repeat (3) @(negedge clk);
    checks++;
    if ({rxDmaReq, txDmaReq, rxEvent, txEvent, rxLevel, txLevel} !== 6'b0) begin
      failures++;
      $display("FAIL R9 actual=%b expected=000000",
               {rxDmaReq, txDmaReq, rxEvent, txEvent, rxLevel, txLevel});
    end
    enable = 1'b0; rxCount = '0;
    @(negedge clk);
    rstN = 1'b1;

    // R1 R3: receive threshold sweep while disabled
    for (int code = 0; code < 4; code++)
      for (int cnt = 0; cnt <= 8; cnt++)
        step(0, 0, cnt, 8, code, 3, 0, 0, "R1_R3 rx sweep");

    // R2 R3: transmit free-slot sweep, including occupancy above depth
    for (int code = 0; code < 4; code++)
      for (int occ = 0; occ <= 10; occ++)
        step(0, 1, 0, occ, 3, code, 0, 0, "R2_R3 tx sweep");

    // R4: DMA burst requests
    for (int cnt = 0; cnt <= 6; cnt++)
      step(1, 0, cnt, 8 - cnt, 2, 2, 0, 0, "R4 dma ramp");
    for (int cnt = 6; cnt >= 0; cnt--)
      step(1, 0, cnt, 8 - cnt, 2, 1, 0, 0, "R4 dma drain");

    // R8: PIO mode gives no DMA requests
    step(1, 1, 0, 8, 1, 1, 0, 0, "R8 enter pio");
    step(1, 1, 1, 8, 1, 1, 0, 0, "R5 below rx thr");
    // R5: rx condition rises
    step(1, 1, 2, 8, 1, 1, 0, 0, "R5 rx rise");
    step(1, 1, 3, 8, 1, 1, 0, 0, "R6 rx hold");
    // R6: stays after condition drops, clear of 0 ignored
    step(1, 1, 0, 8, 1, 1, 0, 0, "R6 rx sticky after drop");
    step(1, 1, 0, 8, 1, 1, 0, 0, "R6 rx no clear");
    step(1, 1, 0, 8, 1, 1, 1, 0, "R6 rx clear");
    step(1, 1, 0, 8, 1, 1, 0, 0, "R6 rx cleared");

    // R5 R10: tx side, clear while condition persists
    step(1, 1, 0, 6, 1, 1, 0, 0, "R5 tx rise");
    step(1, 1, 0, 6, 1, 1, 0, 1, "R10 tx clear while high");
    step(1, 1, 0, 5, 1, 1, 0, 0, "R10 tx stays clear");
    step(1, 1, 0, 4, 1, 1, 0, 0, "R10 tx still clear");
    step(1, 1, 0, 8, 1, 1, 0, 0, "R10 tx condition false");
    step(1, 1, 0, 7, 1, 1, 0, 0, "R10 tx condition false");
    step(1, 1, 0, 6, 1, 1, 0, 0, "R10 tx rise again");

    // R7: new rise coincides with clear
    step(1, 1, 4, 8, 1, 3, 0, 1, "R7 setup");
    step(1, 1, 1, 8, 1, 3, 0, 0, "R7 rx drop");
    step(1, 1, 2, 8, 1, 3, 1, 0, "R7 rise with clear");
    step(1, 1, 2, 8, 1, 3, 0, 0, "R7 held");

    // R8: disabling clears events and blocks everything
    step(1, 1, 8, 0, 3, 3, 0, 0, "R8 both pending");
    step(0, 1, 8, 0, 3, 3, 0, 0, "R8 disable clears");
    step(0, 0, 8, 0, 3, 3, 0, 0, "R8 disabled dma");
    // R5: enabling in PIO with condition already true
    step(1, 1, 8, 0, 3, 3, 0, 0, "R5 enable with level");
    step(1, 1, 8, 0, 3, 3, 0, 0, "R5 held");
    // R8: switching to DMA mode clears events, raises requests
    step(1, 0, 8, 0, 3, 3, 0, 0, "R8 to dma");
    step(1, 0, 7, 1, 3, 3, 0, 0, "R4 below both");
    step(1, 1, 8, 0, 3, 3, 0, 0, "R5 back to pio");
    step(1, 1, 8, 0, 3, 3, 1, 1, "R6 clear both");
    step(1, 1, 8, 0, 3, 3, 0, 0, "R10 both stay clear");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule